// File: doc/BRIEF.md
# Effective Address Generation Sequencer

This block takes an instruction's addressing-mode code and its operand field and produces the value for the memory address register (MAR), together with a choice of segment. Six modes are handled. Immediate and register-direct modes compute no address: they finish at once and leave MAR alone. Register-indirect and memory-direct modes load MAR in one working cycle. Based-indexed and PC-relative modes compute the address over four numbered steps that share one adder. The current step number is shown on a step-code output, so the rest of the datapath can follow the sequence.

A start strobe launches one operation. The block reads general registers through a select output and a data input, and takes the program counter, a direction bit for the relative offset, a byte-select bit and two segment values. MAR is 16 bits wide. The 32-bit linear address is the selected segment placed above MAR. Memory access and instruction decode are done by other blocks.

Top module: `ea_seq`

## Requirements
- R1: After reset, mar, seg_sel, carry, flag_we, step, busy and done are all zero.
- R2: Mode code 0 (immediate, and also the unused codes 6 and 7) leaves mar and seg_sel unchanged. imm_byte becomes operand[7:0] when byte_hi is 0 and operand[15:8] when byte_hi is 1. done is high in the second cycle after the start edge.
- R3: Mode code 1 (register direct) leaves mar and seg_sel unchanged and presents operand[2:0] on rf_sel in the cycle after the start edge. done follows one cycle later.
- R4: Mode code 2 (register indirect) loads mar with the register selected by operand[2:0] and sets seg_sel to 01 (data). done is high in the second cycle after the start edge.
- R5: Mode code 3 (memory direct) loads mar with operand and sets seg_sel to 01. done is high in the second cycle after the start edge.
- R6: Mode code 4 (based-indexed) shows step codes 000, 001, 010 and 011 in the four cycles after the start edge, then raises done. At that point mar equals register operand[2:0] plus register operand[5:3], modulo 2^16, and seg_sel is 01.
- R7: In based-indexed mode, flag_we is 0001 (bit 0 = carry, bits 3:1 = the other flags) during step 010 and zero at every other time. carry takes the carry out of the base plus index sum.
- R8: Mode code 5 (PC-relative) shows the same four step codes. mar ends as pc + operand when sub_dir is 0 and pc - operand when sub_dir is 1, modulo 2^16. flag_we stays zero and carry keeps its previous value.
- R9: seg_sel is 10 (code) after PC-relative mode. lin_addr equals {seg_code, mar} when seg_sel is 10, {seg_data, mar} when it is 01, and {16'h0, mar} when it is 00.
- R10: done is high for exactly one cycle per operation. A start pulse while busy is high is ignored, with no effect on the result and no extra done.
- R11: step is 000 whenever the block is idle and throughout the simple modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe, taken only when idle |
| mode | input | 3 | Addressing-mode code |
| operand | input | 16 | Instruction operand field |
| byte_hi | input | 1 | Immediate byte select: 1 = upper byte |
| sub_dir | input | 1 | PC-relative direction: 1 = subtract offset |
| pc | input | 16 | Program counter |
| rf_data | input | 16 | Register-file read data for rf_sel |
| seg_data | input | 16 | Data segment value |
| seg_code | input | 16 | Code segment value |
| rf_sel | output | 3 | Register-file read select |
| mar | output | 16 | Memory address register |
| seg_sel | output | 2 | Segment in use: 00 none, 01 data, 10 code |
| lin_addr | output | 32 | Segment and MAR combined |
| imm_byte | output | 8 | Selected immediate byte |
| flag_we | output | 4 | Flag write mask during the write step |
| carry | output | 1 | Carry flag |
| step | output | 3 | Micro-step code |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong state register shows up first on step and done. A skipped or repeated step changes the cycle in which done rises and breaks the 000-001-010-011 order, and the bench checks both on every cycle of every operation. A wrong operand register or adder selection shows up in mar and lin_addr when done is high: the bench sweeps all 64 base/index pairs and both offset directions, so a swapped or misrouted register is seen at the end of the very operation that uses it. A bad flag-mask or carry path shows on flag_we during step 010, or on carry after a PC-relative operation.

// File: rtl/ea_seq.sv
module ea_seq #(
  parameter int OFS_W = 16,
  parameter int SEG_W = 16,
  parameter int RA_W  = 3,
  parameter int FL_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [2:0]             mode,
  input  logic [OFS_W-1:0]       operand,
  input  logic                   byte_hi,
  input  logic                   sub_dir,
  input  logic [OFS_W-1:0]       pc,
  input  logic [OFS_W-1:0]       rf_data,
  input  logic [SEG_W-1:0]       seg_data,
  input  logic [SEG_W-1:0]       seg_code,
  output logic [RA_W-1:0]        rf_sel,
  output logic [OFS_W-1:0]       mar,
  output logic [1:0]             seg_sel,
  output logic [SEG_W+OFS_W-1:0] lin_addr,
  output logic [7:0]             imm_byte,
  output logic [FL_W-1:0]        flag_we,
  output logic                   carry,
  output logic [2:0]             step,
  output logic                   busy,
  output logic                   done
);
  localparam logic [2:0] M_IMM = 3'd0, M_RDIR = 3'd1, M_RIND = 3'd2,
                         M_MDIR = 3'd3, M_BIDX = 3'd4, M_PCR = 3'd5;
  localparam logic [1:0] SEG_NONE = 2'b00, SEG_DATA = 2'b01, SEG_CODE = 2'b10;

  typedef enum logic [2:0] {ST_IDLE, ST_ONE, ST_C0, ST_C1, ST_C2, ST_C3, ST_FIN} st_t;
  st_t st;

  logic [2:0]       mode_q;
  logic [OFS_W-1:0] opnd_q, op1_q, op2_q, res_q;
  logic             dir_q, bh_q, cin_q;
  logic [OFS_W:0]   sum;

  wire computed = (mode == M_BIDX) || (mode == M_PCR);

  assign sum = dir_q && (mode_q == M_PCR)
             ? {1'b0, op1_q} - {1'b0, op2_q}
             : {1'b0, op1_q} + {1'b0, op2_q} + {{OFS_W{1'b0}}, cin_q};

  always_comb begin
    case (st)
      ST_IDLE: rf_sel = operand[RA_W-1:0];
      ST_C1:   rf_sel = opnd_q[2*RA_W-1:RA_W];
      default: rf_sel = opnd_q[RA_W-1:0];
    endcase
  end

  always_comb begin
    case (st)
      ST_C1:   step = 3'b001;
      ST_C2:   step = 3'b010;
      ST_C3:   step = 3'b011;
      default: step = 3'b000;
    endcase
  end

  assign busy     = (st != ST_IDLE);
  assign done     = (st == ST_FIN);
  assign flag_we  = (st == ST_C2 && mode_q == M_BIDX) ? FL_W'(1) : '0;
  assign lin_addr = {(seg_sel == SEG_CODE) ? seg_code :
                     (seg_sel == SEG_DATA) ? seg_data : {SEG_W{1'b0}}, mar};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      mode_q <= '0; opnd_q <= '0; dir_q <= 1'b0; bh_q <= 1'b0;
      op1_q <= '0; op2_q <= '0; res_q <= '0; cin_q <= 1'b0;
      mar <= '0; seg_sel <= SEG_NONE; imm_byte <= '0; carry <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          mode_q <= mode; opnd_q <= operand; dir_q <= sub_dir; bh_q <= byte_hi;
          st <= computed ? ST_C0 : ST_ONE;
        end
        ST_ONE: begin
          case (mode_q)
            M_RIND:  begin mar <= rf_data; seg_sel <= SEG_DATA; end
            M_MDIR:  begin mar <= opnd_q;  seg_sel <= SEG_DATA; end
            M_RDIR:  ;
            default: imm_byte <= bh_q ? opnd_q[15:8] : opnd_q[7:0];
          endcase
          st <= ST_FIN;
        end
        ST_C0: begin
          op1_q <= (mode_q == M_PCR) ? pc : rf_data;
          cin_q <= 1'b0;
          st <= ST_C1;
        end
        ST_C1: begin
          op2_q <= (mode_q == M_PCR) ? opnd_q : rf_data;
          st <= ST_C2;
        end
        ST_C2: begin
          res_q <= sum[OFS_W-1:0];
          if (mode_q == M_BIDX) carry <= sum[OFS_W];
          st <= ST_C3;
        end
        ST_C3: begin
          mar <= res_q;
          seg_sel <= (mode_q == M_PCR) ? SEG_CODE : SEG_DATA;
          st <= ST_FIN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 3'b010) |-> ($past(step) == 3'b001)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_IDLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (step == 3'b000)); // R11
  AST_FLAG_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we != '0) |-> (flag_we == FL_W'(1) && step == 3'b010)); // R7
  AST_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mode_q == M_IMM || mode_q == M_RDIR)) |-> ($stable(mar) && $stable(seg_sel))); // R2
  AST_PCR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 3'b011 && mode_q == M_PCR) |-> $stable(carry)); // R8
endmodule

// File: tb/ea_seq_tb.sv
`timescale 1ns/1ps
module ea_seq_tb_top;
  logic clk = 0, rst_n = 0, start = 0, byte_hi = 0, sub_dir = 0;
  logic [2:0] mode = 0;
  logic [15:0] operand = 0, pc = 0, seg_data = 16'hD5A0, seg_code = 16'hC0DE;
  logic [15:0] rf_data;
  logic [2:0] rf_sel, step;
  logic [15:0] mar;
  logic [1:0] seg_sel;
  logic [31:0] lin_addr;
  logic [7:0] imm_byte;
  logic [3:0] flag_we;
  logic carry, busy, done;
  logic [15:0] rf [8];
  int total = 0, bad = 0;
  logic [15:0] e_mar;
  logic [1:0] e_seg;
  logic e_cy;

  always #2.5 clk = ~clk;
  assign rf_data = rf[rf_sel];

  ea_seq dut_i (.clk, .rst_n, .start, .mode, .operand, .byte_hi, .sub_dir, .pc,
    .rf_data, .seg_data, .seg_code, .rf_sel, .mar, .seg_sel, .lin_addr, .imm_byte,
    .flag_we, .carry, .step, .busy, .done);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] m, input logic [15:0] op, input bit d, input bit bh, input bit poke);
    int cyc;
    bit comp;
    logic [16:0] s;
    comp = (m == 3'd4 || m == 3'd5);
    @(negedge clk);
    mode = m; operand = op; sub_dir = d; byte_hi = bh; start = 1;
    @(negedge clk);
    start = 0;
    cyc = 1;
    while (!done && cyc < 20) begin
      if (comp) begin
        chk(step == 3'(cyc - 1), m == 4 ? "R6 step" : "R8 step", 32'(step), 32'(cyc - 1));
        chk(flag_we == ((m == 4 && cyc == 3) ? 4'b0001 : 4'b0000), m == 4 ? "R7 flag_we" : "R8 flag_we",
            32'(flag_we), 32'((m == 4 && cyc == 3) ? 1 : 0));
      end else begin
        chk(step == 3'd0, "R11 step", 32'(step), 0);
        if (m == 3'd1) chk(rf_sel == op[2:0], "R3 rf_sel", 32'(rf_sel), 32'(op[2:0]));
      end
      if (poke && cyc == 2) begin
        start = 1; mode = 3'd3; operand = 16'hDEAD;
      end else start = 0;
      @(negedge clk);
      cyc++;
    end
    start = 0;
    chk(cyc == (comp ? 5 : 2), "R10 latency", 32'(cyc), comp ? 5 : 2);
    case (m)
      3'd2: begin e_mar = rf[op[2:0]]; e_seg = 2'b01; end
      3'd3: begin e_mar = op; e_seg = 2'b01; end
      3'd4: begin
        s = {1'b0, rf[op[2:0]]} + {1'b0, rf[op[5:3]]};
        e_mar = s[15:0]; e_seg = 2'b01; e_cy = s[16];
      end
      3'd5: begin e_mar = d ? pc - op : pc + op; e_seg = 2'b10; end
      default: ;
    endcase
    if (m == 3'd0) chk(imm_byte == (bh ? op[15:8] : op[7:0]), "R2 imm_byte", 32'(imm_byte), 32'(bh ? op[15:8] : op[7:0]));
    chk(mar == e_mar, m < 2 ? "R2/R3 mar held" : m == 4 ? "R6 mar" : m == 5 ? "R8 mar" : m == 2 ? "R4 mar" : "R5 mar",
        32'(mar), 32'(e_mar));
    chk(seg_sel == e_seg, "R9 seg_sel", 32'(seg_sel), 32'(e_seg));
    chk(lin_addr == {(e_seg == 2'b10) ? seg_code : (e_seg == 2'b01) ? seg_data : 16'h0, e_mar},
        "R9 lin_addr", lin_addr, {(e_seg == 2'b10) ? seg_code : (e_seg == 2'b01) ? seg_data : 16'h0, e_mar});
    chk(carry == e_cy, m == 4 ? "R7 carry" : "R8 carry held", 32'(carry), 32'(e_cy));
    for (int k = 0; k < (poke ? 4 : 1); k++) begin
      @(negedge clk);
      chk(!done && !busy, "R10 single done", 32'({busy, done}), 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) rf[i] = 16'(i * 16'h2345 + 16'h7001);
    rf[7] = 16'hFFFF;
    #12;
    chk(mar == 0 && seg_sel == 0 && carry == 0 && flag_we == 0 && step == 0 && !busy && !done,
        "R1 reset", {mar, 6'b0, seg_sel, carry, flag_we, step, busy, done}, 0);
    rst_n = 1;
    e_mar = 0; e_seg = 0; e_cy = 0;
    run(3'd0, 16'hA55A, 0, 0, 0);
    run(3'd0, 16'hA55A, 0, 1, 0);
    run(3'd6, 16'h1234, 0, 1, 0);
    for (int r = 0; r < 8; r++) begin
      run(3'd1, 16'(16'h3C0 | r), 0, 0, 0);
      run(3'd2, 16'(16'hF800 | r), 0, 0, 0);
    end
    run(3'd3, 16'hBEEF, 0, 0, 0);
    run(3'd0, 16'h00C3, 0, 0, 0);
    for (int b = 0; b < 8; b++)
      for (int x = 0; x < 8; x++)
        run(3'd4, {10'h155, 3'(x), 3'(b)}, 0, 0, 0);
    for (int p = 0; p < 4; p++) begin
      pc = 16'(p * 16'h5123 + 16'h0010);
      run(3'd5, 16'(16'h0F00 + p * 16'h3001), 0, 0, 0);
      run(3'd5, 16'(16'h0F00 + p * 16'h3001), 1, 0, 0);
    end
    run(3'd4, 16'h003F, 0, 0, 1);
    pc = 16'h1000;
    run(3'd5, 16'h2000, 1, 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule